// File: doc/BRIEF.md
# Bit Count Unit with Flags

This unit takes one operand per cycle and returns one of three counts over it: the number of one bits, the number of zero bits above the highest one, or the number of zero bits below the lowest one. A width select picks whether the operand is 32 or 64 bits wide. An operation code picks the count. Two further codes switch the unit to the older scan behaviour. These return the bit index of the lowest or highest one bit, and for a zero source they return no new result.

The count and the two flags (carry and zero) are captured in one register stage. A valid strobe marks each accepted operand and comes back exactly one cycle later. For the scan codes the caller also supplies the current destination value. The unit passes it back unchanged when the source has no set bit, so the caller sees the destination left as it was.

Top module: `bcu_top`

## Requirements
- R1: Operation code 0 (population count) returns the number of one bits in the examined operand, with CF cleared and ZF set exactly when the count is zero.
- R2: Operation code 1 (leading-zero count) returns the number of zero bits above the highest one bit within the selected width, and returns the width (32 or 64) for a zero source.
- R3: Operation code 2 (trailing-zero count) returns the number of zero bits below the lowest one bit, and returns the width (32 or 64) for a zero source.
- R4: For codes 1 and 2, CF is set exactly when the examined source is zero and ZF is set exactly when the result is zero; the two flags are never set together on any output.
- R5: Operation code 3 (forward scan) on a nonzero source returns the index of the lowest one bit, equal to the trailing-zero count, with ZF and CF cleared.
- R6: Operation code 4 (reverse scan) on a nonzero source returns the index of the highest one bit, so that it plus the leading-zero count equals width minus 1 (32-bit source 0x000f0000 gives 19 against 12), with ZF and CF cleared.
- R7: For codes 3 and 4 with a zero source, ZF is set, CF is cleared and the result equals the supplied previous destination value (its low 32 bits, zero-extended, when the width select is 32).
- R8: With the width select low (32-bit mode), only operand bits 31:0 are examined and result bits 63:32 are zero.
- R9: out_valid is high in exactly the cycle after a cycle with in_valid high, and result and flags change only at that edge.
- R10: While in_valid is low, result, cf and zf hold their last values whatever the other inputs do.
- R11: Codes 5 to 7 are reserved: an accepted operation with such a code returns a zero result with both flags cleared.
- R12: After reset, out_valid, result, cf and zf are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and code are to be taken this cycle |
| wide | input | 1 | 1 selects a 64-bit operand, 0 a 32-bit operand |
| op | input | 3 | Operation code (0 pop, 1 lead, 2 trail, 3 fwd scan, 4 rev scan) |
| operand | input | 64 | Source value |
| prev_dest | input | 64 | Current destination value, returned by scans of a zero source |
| out_valid | output | 1 | Result and flags belong to the operation of the previous cycle |
| result | output | 64 | Registered count or index |
| cf | output | 1 | Registered carry flag |
| zf | output | 1 | Registered zero flag |

## Verification
The assertions take all inputs to be known values in every cycle after reset. They also take op, wide, operand and prev_dest to be sampled at the same edge as in_valid, with no multi-cycle hold assumed. The stimulus changes every input only on the falling clock edge and drives a defined value on each one at all times. While in_valid is low it deliberately scrambles operand, op and prev_dest, so the hold property is exercised against live changes.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int unsigned DATA_W  = 64;
    localparam int unsigned HALF_W  = DATA_W / 2;
    localparam int unsigned CNT_W   = $clog2(DATA_W) + 1;
    localparam int unsigned IDX_W   = $clog2(DATA_W);
    localparam int unsigned OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_POP   = 3'd0,
        OP_LEAD  = 3'd1,
        OP_TRAIL = 3'd2,
        OP_SCANF = 3'd3,
        OP_SCANR = 3'd4,
        OP_RSV5  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } bcu_op_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic              cf;
        logic              zf;
    } bcu_state_t;

endpackage

// File: rtl/bcu_popcount.sv
module bcu_popcount #(
    parameter int unsigned W = 64,
    localparam int unsigned CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bcu_msb_find.sv
module bcu_msb_find #(
    parameter int unsigned W = 64,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcu_top.sv
module bcu_top
    import bcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              wide,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] prev_dest,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              cf,
    output logic              zf
);
    bcu_state_t        st_d, st_q;
    bcu_op_e           op_e;
    logic [DATA_W-1:0] src_m, src_rev, prev_m;
    logic [CNT_W-1:0]  pop_cnt, width_val, lead_cnt, trail_cnt;
    logic [IDX_W-1:0]  hi_idx, rev_idx;
    logic              hi_found, rev_found, src_zero;

    assign op_e     = bcu_op_e'(op);
    // R8: narrow mode ignores the upper half of both inputs
    assign src_m    = wide ? operand   : {{HALF_W{1'b0}}, operand[HALF_W-1:0]};
    assign prev_m   = wide ? prev_dest : {{HALF_W{1'b0}}, prev_dest[HALF_W-1:0]};
    assign width_val = wide ? CNT_W'(DATA_W) : CNT_W'(HALF_W);

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_rev
            assign src_rev[g] = src_m[DATA_W-1-g];
        end
    endgenerate

    bcu_popcount #(.W(DATA_W)) u_pop (
        .vec   (src_m),
        .count (pop_cnt)
    );

    bcu_msb_find #(.W(DATA_W)) u_hi (
        .vec   (src_m),
        .idx   (hi_idx),
        .found (hi_found)
    );

    // highest set bit of the reversed vector marks the lowest set bit
    bcu_msb_find #(.W(DATA_W)) u_lo (
        .vec   (src_rev),
        .idx   (rev_idx),
        .found (rev_found)
    );

    assign src_zero  = !hi_found;
    assign lead_cnt  = src_zero ? width_val
                                : width_val - CNT_W'(1) - CNT_W'(hi_idx);
    assign trail_cnt = !rev_found ? width_val
                                  : CNT_W'(DATA_W - 1) - CNT_W'(rev_idx);

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = '0;
            st_d.cf     = 1'b0;
            st_d.zf     = 1'b0;
            case (op_e)
                OP_POP: begin
                    st_d.result = DATA_W'(pop_cnt);
                    st_d.zf     = (pop_cnt == '0);
                end
                OP_LEAD: begin
                    st_d.result = DATA_W'(lead_cnt);
                    st_d.cf     = src_zero;
                    st_d.zf     = (lead_cnt == '0);
                end
                OP_TRAIL: begin
                    st_d.result = DATA_W'(trail_cnt);
                    st_d.cf     = src_zero;
                    st_d.zf     = (trail_cnt == '0);
                end
                OP_SCANF: begin
                    st_d.result = src_zero ? prev_m : DATA_W'(trail_cnt);
                    st_d.zf     = src_zero;
                end
                OP_SCANR: begin
                    st_d.result = src_zero ? prev_m : DATA_W'(hi_idx);
                    st_d.zf     = src_zero;
                end
                default: begin
                    st_d.result = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign cf        = st_q.cf;
    assign zf        = st_q.zf;

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(cf) && $stable(zf)));
    p_narrow_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[DATA_W-1:HALF_W] == '0));
    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(cf && zf));
    p_lead_zero_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && op == 3'd1 && operand == '0)
            |=> (cf && !zf && result == DATA_W'(DATA_W)));
    p_scan_zero_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && (op == 3'd3 || op == 3'd4) && operand == '0)
            |=> (zf && !cf && result == $past(prev_dest)));
    p_reserved_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 3'd5) |=> (result == '0 && !cf && !zf));
endmodule

// File: tb/test_bcu_top.sv
module test_bcu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        wide = 1'b1;
    logic [2:0]  op = 3'd0;
    logic [63:0] operand = '0;
    logic [63:0] prev_dest = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        cf, zf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bcu_top i_bcu_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .wide      (wide),
        .op        (op),
        .operand   (operand),
        .prev_dest (prev_dest),
        .out_valid (out_valid),
        .result    (result),
        .cf        (cf),
        .zf        (zf)
    );

    function automatic logic [63:0] narrow_of(input logic w, input logic [63:0] v);
        return w ? v : {32'd0, v[31:0]};
    endfunction
    function automatic int ref_pop(input logic [63:0] v);
        int n = 0;
        foreach (v[i]) if (v[i]) n++;
        return n;
    endfunction
    function automatic int ref_lead(input int w, input logic [63:0] v);
        int n = 0;
        while (n < w && !v[w-1-n]) n++;
        return n;
    endfunction
    function automatic int ref_trail(input int w, input logic [63:0] v);
        int n = 0;
        while (n < w && !v[n]) n++;
        return n;
    endfunction

    task automatic chk(input string req, input bit ok, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic w, input logic [2:0] c, input logic [63:0] v,
                         input logic [63:0] pd);
        @(negedge clk);
        in_valid = 1'b1; wide = w; op = c; operand = v; prev_dest = pd;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [63:0] er,
                              input logic ecf, input logic ezf);
        chk(req, out_valid === 1'b1, {63'd0, out_valid}, 64'd1);
        chk(req, result === er, result, er);
        chk(req, {cf, zf} === {ecf, ezf}, {62'd0, cf, zf}, {62'd0, ecf, ezf});
    endtask

    task automatic t_reset();
        chk("R12", {out_valid, cf, zf} === 3'b000, {61'd0, out_valid, cf, zf}, 64'd0);
        chk("R12", result === 64'd0, result, 64'd0);
    endtask

    task automatic t_pop();
        logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                                 64'h8000_0000_0000_0001, 64'h1234_5678_9ABC_DEF0};
        foreach (pats[k]) begin
            int n = ref_pop(pats[k]);
            issue(1'b1, 3'd0, pats[k], '0);
            expect_out("R1", 64'(n), 1'b0, n == 0);
        end
    endtask

    task automatic t_lead();
        logic [63:0] pats [4] = '{64'h1, 64'h8000_0000_0000_0000,
                                 64'h0000_0001_0000_0000, 64'h0};
        foreach (pats[k]) begin
            int n = ref_lead(64, pats[k]);
            issue(1'b1, 3'd1, pats[k], '0);
            expect_out("R2 R4", 64'(n), pats[k] == 0, n == 0);
        end
        issue(1'b0, 3'd1, 64'hFFFF_FFFF_0000_0000, '0);
        expect_out("R2 R4 zero32", 64'd32, 1'b1, 1'b0);
    endtask

    task automatic t_trail();
        logic [63:0] pats [4] = '{64'h8000_0000_0000_0000, 64'h1,
                                 64'h0000_0100_0000_0000, 64'h0};
        foreach (pats[k]) begin
            int n = ref_trail(64, pats[k]);
            issue(1'b1, 3'd2, pats[k], '0);
            expect_out("R3 R4", 64'(n), pats[k] == 0, n == 0);
        end
        issue(1'b0, 3'd2, 64'h0000_0001_0000_0000, '0);
        expect_out("R3 R4 zero32", 64'd32, 1'b1, 1'b0);
    endtask

    task automatic t_scan_fwd();
        logic [63:0] v = 64'h0040_0000_0000_0000;
        issue(1'b1, 3'd3, v, 64'hDEAD);
        expect_out("R5", 64'(ref_trail(64, v)), 1'b0, 1'b0);
        issue(1'b1, 3'd3, 64'h1, 64'hDEAD);
        expect_out("R5 index0", 64'd0, 1'b0, 1'b0);
    endtask

    task automatic t_scan_rev();
        logic [63:0] lead_r;
        issue(1'b0, 3'd1, 64'h0000_0000_000F_0000, '0);
        lead_r = result;
        chk("R6 lead", lead_r === 64'd12, lead_r, 64'd12);
        issue(1'b0, 3'd4, 64'h0000_0000_000F_0000, 64'hBEEF);
        expect_out("R6", 64'd19, 1'b0, 1'b0);
        chk("R6 identity", result + lead_r === 64'd31, result + lead_r, 64'd31);
        issue(1'b1, 3'd4, 64'h8000_0000_0000_0000, '0);
        expect_out("R6 top", 64'd63, 1'b0, 1'b0);
    endtask

    task automatic t_scan_zero();
        issue(1'b1, 3'd3, 64'h0, 64'hCAFE_F00D_1234_5678);
        expect_out("R7 fwd", 64'hCAFE_F00D_1234_5678, 1'b0, 1'b1);
        issue(1'b1, 3'd4, 64'h0, 64'h0123_4567_89AB_CDEF);
        expect_out("R7 rev", 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1);
        issue(1'b0, 3'd4, 64'hFFFF_0000_0000_0000, 64'hAAAA_BBBB_CCCC_DDDD);
        expect_out("R7 R8 narrow", 64'h0000_0000_CCCC_DDDD, 1'b0, 1'b1);
    endtask

    task automatic t_narrow();
        logic [63:0] v = 64'hF0F0_F0F0_0000_0300;
        issue(1'b0, 3'd0, v, '0);
        expect_out("R8 pop", 64'(ref_pop(narrow_of(1'b0, v))), 1'b0, 1'b0);
        issue(1'b0, 3'd1, v, '0);
        expect_out("R8 lead", 64'(ref_lead(32, narrow_of(1'b0, v))), 1'b0, 1'b0);
    endtask

    task automatic t_timing_idle();
        logic [63:0] held;
        issue(1'b1, 3'd0, 64'hFF, '0);
        held = result;
        chk("R9 valid", out_valid === 1'b1, {63'd0, out_valid}, 64'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            operand = 64'h5555_0000_0000_0000 + 64'(k); op = 3'(k + 1);
            prev_dest = ~prev_dest;
        end
        chk("R9 drop", out_valid === 1'b0, {63'd0, out_valid}, 64'd0);
        chk("R10 hold", result === held && cf === 1'b0 && zf === 1'b0, result, held);
    endtask

    task automatic t_reserved();
        for (int c = 5; c < 8; c++) begin
            issue(1'b1, 3'(c), 64'h0, 64'h1234);
            expect_out("R11", 64'd0, 1'b0, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pop();
        t_lead();
        t_trail();
        t_scan_fwd();
        t_scan_rev();
        t_scan_zero();
        t_narrow();
        t_timing_idle();
        t_reserved();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule